// File: doc/BRIEF.md
# Loadable Up/Down Counter with Look-Ahead Output

This block is a binary counter for a single clock domain. The counting direction is fixed when the block is built and is either upward or downward. The block updates on the rising clock edge. It has a synchronous reset, a global enable that gates every update except reset, a step enable, and a synchronous load that writes an external value into the count. If load and step are asserted in the same cycle, the load wins.

The present count is driven straight from the count register, so it reaches the port with no extra output stage. A second output gives the value the counter will reach after a fixed number of further steps in its own direction. Both outputs wrap modulo 2^width. A one-cycle flag marks each step that wraps around the end of the range: from the maximum to zero when counting up, and from zero to the maximum when counting down.

Parameters set the width, the power-up value, the reset value, the direction and the look-ahead distance. The power-up value and the reset value are separate parameters and may differ.

Top module: `step_counter`

## Requirements
- R1: When `srst_i` is high at a rising edge, `count_o` becomes `RST_VAL` and `wrap_o` becomes 0 after that edge. This holds whatever `en_i`, `load_i` and `step_i` are.
- R2: Before any clock edge, `count_o` equals `PWRUP_VAL` and `wrap_o` is 0. `PWRUP_VAL` may differ from `RST_VAL`.
- R3: At an edge where `en_i` is low and reset is low, `count_o` keeps its value, even if `load_i` or `step_i` is high. After that edge `wrap_o` is 0.
- R4: At an enabled edge with `load_i` high, `count_o` takes `load_val_i` and `wrap_o` becomes 0. This holds even when `step_i` is also high.
- R5: At an enabled edge with `load_i` low and `step_i` high, `count_o` moves by one, modulo 2^`CNT_W`. It moves +1 when `DIR` is `CNT_UP` and -1 when `DIR` is `CNT_DOWN`.
- R6: At an enabled edge with both `load_i` and `step_i` low, `count_o` holds and `wrap_o` becomes 0.
- R7: `ahead_o` equals `count_o` plus `AHEAD` in up mode, or `count_o` minus `AHEAD` in down mode, modulo 2^`CNT_W`. It follows `count_o` in the same cycle. With `AHEAD` = 0 it equals `count_o`.
- R8: `wrap_o` is high for exactly the one cycle that follows an R5 step that went from all-ones to zero (up mode) or from zero to all-ones (down mode). It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge active |
| srst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Global enable for load and step |
| step_i | input | 1 | Step enable, active high |
| load_i | input | 1 | Synchronous load; has priority over step |
| load_val_i | input | CNT_W | Value written by a load |
| count_o | output | CNT_W | Present count, taken straight from the register |
| ahead_o | output | CNT_W | Count offset by AHEAD steps in the counting direction |
| wrap_o | output | 1 | One-cycle flag for a wrapping step |

## Verification
On every cycle, the assertions check the following:
- the reset result;
- that the count holds while disabled;
- that a load wins over a step;
- the single-step relation between consecutive counts;
- the fixed distance between `ahead_o` and `count_o`;
- that every raised wrap flag matches an actual wrap, and that every wrap raises the flag.

Only the bench scenarios can show the power-up value before the first edge. Only they compare the absolute count values against an independent model along long step runs, full sweeps of the load value and both wrap boundaries. The bench does this for an up counter and a down counter side by side, each with its own power-up value, reset value and look-ahead distance.

// File: rtl/step_counter_pkg.sv
package step_counter_pkg;
   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_dir_e;
endpackage

// File: rtl/step_counter_next.sv
module step_counter_next
   import step_counter_pkg::*;
#(
   parameter int       CNT_W = 4,
   parameter cnt_dir_e DIR   = CNT_UP
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] nxt_o,
   output logic             edge_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (DIR == CNT_UP) begin : g_up
         assign nxt_o  = cnt_i + ONE;
         assign edge_o = &cnt_i;
      end else begin : g_down
         assign nxt_o  = cnt_i - ONE;
         assign edge_o = ~|cnt_i;
      end
   endgenerate
endmodule

// File: rtl/step_counter_ahead.sv
module step_counter_ahead
   import step_counter_pkg::*;
#(
   parameter int       CNT_W = 4,
   parameter cnt_dir_e DIR   = CNT_UP,
   parameter int       AHEAD = 0
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] ahead_o
);
   localparam logic [CNT_W-1:0] DIST = CNT_W'(AHEAD);

   generate
      if (AHEAD == 0) begin : g_zero
         assign ahead_o = cnt_i;
      end else if (DIR == CNT_UP) begin : g_up
         assign ahead_o = cnt_i + DIST;
      end else begin : g_down
         assign ahead_o = cnt_i - DIST;
      end
   endgenerate
endmodule

// File: rtl/step_counter.sv
module step_counter
   import step_counter_pkg::*;
#(
   parameter int       CNT_W     = 4,
   parameter int       PWRUP_VAL = 0,
   parameter int       RST_VAL   = 0,
   parameter cnt_dir_e DIR       = CNT_UP,
   parameter int       AHEAD     = 0
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic             en_i,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] ahead_o,
   output logic             wrap_o
);
   localparam longint           SPAN       = longint'(1) << CNT_W;
   localparam logic [CNT_W-1:0] START_VAL  = CNT_W'(PWRUP_VAL);
   localparam logic [CNT_W-1:0] RESET_VAL  = CNT_W'(RST_VAL);
   localparam logic [CNT_W-1:0] STEP_DELTA = (DIR == CNT_UP) ? CNT_W'(1) : {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] AHEAD_DIFF = (DIR == CNT_UP) ? CNT_W'(AHEAD) : CNT_W'(0) - CNT_W'(AHEAD);
   localparam logic [CNT_W-1:0] WRAP_FROM  = (DIR == CNT_UP) ? {CNT_W{1'b1}} : '0;
   localparam logic [CNT_W-1:0] WRAP_TO    = (DIR == CNT_UP) ? '0 : {CNT_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_width
         $error("step_counter: CNT_W must lie in 1..31");
      end
      if (PWRUP_VAL < 0 || longint'(PWRUP_VAL) >= SPAN) begin : g_bad_pwrup
         $error("step_counter: PWRUP_VAL out of range");
      end
      if (RST_VAL < 0 || longint'(RST_VAL) >= SPAN) begin : g_bad_rst
         $error("step_counter: RST_VAL out of range");
      end
      if (AHEAD < 0 || longint'(AHEAD) >= SPAN) begin : g_bad_ahead
         $error("step_counter: AHEAD out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q = START_VAL;
   logic             wrap_q = 1'b0;
   logic [CNT_W-1:0] cnt_nxt;
   logic             at_edge;
   logic             do_load;
   logic             do_step;

   step_counter_next #(
      .CNT_W (CNT_W),
      .DIR   (DIR)
   ) next_i (
      .cnt_i  (cnt_q),
      .nxt_o  (cnt_nxt),
      .edge_o (at_edge)
   );

   step_counter_ahead #(
      .CNT_W (CNT_W),
      .DIR   (DIR),
      .AHEAD (AHEAD)
   ) ahead_i (
      .cnt_i   (cnt_q),
      .ahead_o (ahead_o)
   );

   assign do_load = en_i & load_i;
   assign do_step = en_i & ~load_i & step_i;

   // priority: reset, then load, then step
   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         cnt_q  <= RESET_VAL;
         wrap_q <= 1'b0;
      end else begin
         if (do_load) begin
            cnt_q <= load_val_i;
         end else if (do_step) begin
            cnt_q <= cnt_nxt;
         end
         wrap_q <= do_step & at_edge;
      end
   end

   assign count_o = cnt_q;
   assign wrap_o  = wrap_q;

   p_reset_r1: assert property (@(posedge clk_i)
      srst_i |=> (count_o == RESET_VAL) && !wrap_o);

   p_hold_r3: assert property (@(posedge clk_i) disable iff (srst_i)
      !en_i |=> $stable(count_o) && !wrap_o);

   p_load_wins_r4: assert property (@(posedge clk_i) disable iff (srst_i)
      (en_i && load_i) |=> (count_o == $past(load_val_i)) && !wrap_o);

   p_step_r5: assert property (@(posedge clk_i) disable iff (srst_i)
      (en_i && !load_i && step_i) |=> (count_o == $past(count_o) + STEP_DELTA));

   p_idle_r6: assert property (@(posedge clk_i) disable iff (srst_i)
      (en_i && !load_i && !step_i) |=> $stable(count_o) && !wrap_o);

   p_ahead_r7: assert property (@(posedge clk_i)
      CNT_W'(ahead_o - count_o) == AHEAD_DIFF);

   p_wrap_real_r8: assert property (@(posedge clk_i) disable iff (srst_i)
      wrap_o |-> (count_o == WRAP_TO));

   p_wrap_seen_r8: assert property (@(posedge clk_i) disable iff (srst_i)
      (en_i && !load_i && step_i && count_o == WRAP_FROM) |=> wrap_o);
endmodule

// File: tb/step_counter_tb_top.sv
module step_counter_tb_top;
   import step_counter_pkg::*;

   localparam int W      = 4;
   localparam int M      = 1 << W;
   localparam int U_PWR  = 5;
   localparam int U_RST  = 9;
   localparam int U_AH   = 3;
   localparam int D_PWR  = 12;
   localparam int D_RST  = 1;
   localparam int D_AH   = 2;

   logic         clk = 1'b0;
   logic         srst = 1'b0;
   logic         en = 1'b0;
   logic         step = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] lval = '0;
   logic [W-1:0] u_cnt, u_ahd, d_cnt, d_ahd;
   logic         u_wrap, d_wrap;

   int n_chk = 0;
   int n_err = 0;
   int eu, ed, wu, wd;

   always #2 clk = ~clk;

   step_counter #(.CNT_W(W), .PWRUP_VAL(U_PWR), .RST_VAL(U_RST),
                  .DIR(CNT_UP), .AHEAD(U_AH)) dut_i (
      .clk_i(clk), .srst_i(srst), .en_i(en), .step_i(step), .load_i(load),
      .load_val_i(lval), .count_o(u_cnt), .ahead_o(u_ahd), .wrap_o(u_wrap));

   step_counter #(.CNT_W(W), .PWRUP_VAL(D_PWR), .RST_VAL(D_RST),
                  .DIR(CNT_DOWN), .AHEAD(D_AH)) dut_dn_i (
      .clk_i(clk), .srst_i(srst), .en_i(en), .step_i(step), .load_i(load),
      .load_val_i(lval), .count_o(d_cnt), .ahead_o(d_ahd), .wrap_o(d_wrap));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "up count", int'(u_cnt), eu);
      chk(tag, "up wrap", int'(u_wrap), wu);
      chk("R7", "up ahead", int'(u_ahd), (eu + U_AH) % M);
      chk(tag, "down count", int'(d_cnt), ed);
      chk(tag, "down wrap", int'(d_wrap), wd);
      chk("R7", "down ahead", int'(d_ahd), (ed - D_AH + M) % M);
   endtask

   // drive at negedge, clock one edge, model, check at next negedge
   task automatic cyc(input string tag, input logic r, input logic e,
                      input logic s, input logic l, input int v);
      srst = r; en = e; step = s; load = l; lval = W'(v);
      @(posedge clk);
      if (r) begin
         eu = U_RST; ed = D_RST; wu = 0; wd = 0;
      end else if (e && l) begin
         eu = v; ed = v; wu = 0; wd = 0;
      end else if (e && s) begin
         wu = (eu == M - 1) ? 1 : 0;
         wd = (ed == 0) ? 1 : 0;
         eu = (eu + 1) % M;
         ed = (ed - 1 + M) % M;
      end else begin
         wu = 0; wd = 0;
      end
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // R2: power-up values before any edge
      #1;
      eu = U_PWR; ed = D_PWR; wu = 0; wd = 0;
      check_all("R2");
      @(negedge clk);
      // R3: disabled, load and step ignored
      cyc("R3", 0, 0, 1, 1, 7);
      cyc("R3", 0, 0, 1, 0, 0);
      // R1: reset acts with enable low, and over load
      cyc("R1", 1, 0, 0, 0, 0);
      cyc("R1", 1, 1, 1, 1, 6);
      // R5 / R8: long step run covers both wraps
      for (int i = 0; i < 40; i++) cyc("R5_R8", 0, 1, 1, 0, 0);
      // R6: enabled idle
      for (int i = 0; i < 3; i++) cyc("R6", 0, 1, 0, 0, 0);
      // R4: load sweep with step also high, then one step
      for (int v = 0; v < M; v++) begin
         cyc("R4", 0, 1, 1, 1, v);
         cyc("R5", 0, 1, 1, 0, 0);
      end
      // R8: boundary loads then wrapping step, flag then clears
      cyc("R4", 0, 1, 0, 1, M - 1);
      cyc("R8", 0, 1, 1, 0, 0);
      cyc("R8", 0, 1, 1, 0, 0);
      cyc("R4", 0, 1, 0, 1, 0);
      cyc("R8", 0, 1, 1, 0, 0);
      cyc("R8", 0, 0, 1, 0, 0);
      // R3: hold mid-run, with load value present
      for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 1, 1, i + 3);
      // R1: reset while stepping
      cyc("R1", 1, 1, 1, 0, 0);
      cyc("R5", 0, 1, 1, 0, 0);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule